// File: doc/BRIEF.md
# Timer Compare-Match Waveform Output

This block is a small up/down timer with a single compare channel whose result drives one output pin. A W-bit counter (8 bits by default) advances once per `tick` pulse. How it advances depends on a 2-bit counting mode: free-running, clear-on-compare, single-slope pulse-width, or dual-slope pulse-width. The comparison of the counter with a programmed compare value produces a one-cycle match flag. A 2-bit output action then decides what a match does to a one-bit waveform register.

Configuration arrives through one write strobe. The strobe loads the compare value, the output action, the counting mode, the pin direction and the general port data bit together. A separate force strobe applies the selected action at once in the two non-PWM modes. This lets software preset the waveform level before the pin is enabled. The pin carries the waveform register whenever the action field is nonzero and the port data bit otherwise. The output enable is the direction bit and nothing else.

Counting modes: 0 free-running, 1 dual-slope PWM, 2 clear-on-compare, 3 single-slope PWM. MAX below is the all-ones counter value. "Match" means a tick that arrives while the counter equals the compare value.

Top module: `cmp_wave_timer`

## Requirements
- R1: After reset the counter is 0, the match flag is 0, the waveform register is 0, the action field is 0, and the port data bit and the direction bit are 0. As a result `pin_out` and `pin_oe` are both 0.
- R2: In mode 0 each tick adds one to the counter, and MAX wraps to 0. With `tick` low the counter holds.
- R3: In mode 2 the counter goes to 0 on a tick while it equals the compare value and otherwise adds one. In every mode `match` is high during the cycle after a tick taken with counter equal to the compare value, and low after any other cycle.
- R4: In modes 0 and 2 a match acts on the waveform register by action code: 1 toggles it, 2 clears it, 3 sets it, and 0 leaves it unchanged.
- R5: Writing a new action code never changes the waveform register by itself. The new code takes effect at the next match (or force).
- R6: In modes 0 and 2 a force strobe applies the current action to the waveform register in the next cycle. It neither changes the counter nor raises `match`.
- R7: In modes 1 and 3 a force strobe leaves the waveform register unchanged.
- R8: In mode 3 the counter runs 0 to MAX and wraps. Once settled with action 2, the pin is high exactly while counter <= compare value. Action 3 gives the complement.
- R9: In mode 1 the counter runs 0 up to MAX and back down to 0, repeating. With action 2 a match clears the waveform while counting up and sets it while counting down. With action 3 it does the reverse. Compare value 0 therefore gives a constant low (action 2), and compare value MAX gives a constant high (action 2).
- R10: `pin_out` shows the waveform register when the action code is nonzero and the port data bit when it is 0, in every mode. `pin_oe` equals the direction bit.
- R11: The action code has no effect on the counting sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| cfg_we | input | 1 | Loads all configuration fields below |
| cfg_cmp | input | W | Compare value |
| cfg_act | input | 2 | Output action code |
| cfg_mode | input | 2 | Counting mode |
| cfg_dir | input | 1 | Pin direction, 1 = drive |
| cfg_port | input | 1 | General port data bit |
| force_act | input | 1 | Force strobe for the output action |
| count | output | W | Counter value |
| match | output | 1 | Compare-match flag, one cycle |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The embedded properties watch, on every cycle, the step rules of the counter. These are the free-running wrap, the clear in mode 2, the hold without a tick and the turn at MAX in dual-slope mode. They also check that the flag stays low without a tick, that a forced clear lands, and that force is inert in PWM modes. Only the bench scenarios can show the full pin waveform against the compare value across every compare setting. They also show toggle parity over many matches, the deferred effect of a rewritten action code, and the edge settings 0 and MAX in both PWM modes.

// File: rtl/cmp_wave_timer.sv
`timescale 1ns/1ps
module cmp_wave_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_cmp,
  input  logic [1:0]   cfg_act,
  input  logic [1:0]   cfg_mode,
  input  logic         cfg_dir,
  input  logic         cfg_port,
  input  logic         force_act,
  output logic [W-1:0] count,
  output logic         match,
  output logic         pin_out,
  output logic         pin_oe
);

  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [1:0] M_NORM  = 2'd0;
  localparam logic [1:0] M_PHASE = 2'd1;
  localparam logic [1:0] M_CTC   = 2'd2;
  localparam logic [1:0] M_FAST  = 2'd3;

  logic [W-1:0] cmp_r, cnt_r, cnt_nxt;
  logic [1:0]   act_r, mode_r;
  logic         dir_r, port_r, dn_r, dn_nxt, wave_r, wave_nxt, match_r;
  logic         pwm, eq, down;

  assign pwm  = (mode_r == M_PHASE) || (mode_r == M_FAST);
  assign eq   = (cnt_r == cmp_r);
  assign down = dn_r || (cnt_r == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_r  <= '0;
      act_r  <= 2'd0;
      mode_r <= M_NORM;
      dir_r  <= 1'b0;
      port_r <= 1'b0;
    end else if (cfg_we) begin
      cmp_r  <= cfg_cmp;
      act_r  <= cfg_act;
      mode_r <= cfg_mode;
      dir_r  <= cfg_dir;
      port_r <= cfg_port;
    end
  end

  always_comb begin
    dn_nxt = 1'b0;
    case (mode_r)
      M_CTC:   cnt_nxt = eq ? '0 : cnt_r + ONE;
      M_PHASE: begin
        cnt_nxt = down ? cnt_r - ONE : cnt_r + ONE;
        dn_nxt  = down && (cnt_r != ONE);
      end
      default: cnt_nxt = cnt_r + ONE;
    endcase
  end

  always_comb begin
    wave_nxt = wave_r;
    if (!pwm) begin
      if ((tick && eq) || force_act) begin
        case (act_r)
          2'd1:    wave_nxt = ~wave_r;
          2'd2:    wave_nxt = 1'b0;
          2'd3:    wave_nxt = 1'b1;
          default: wave_nxt = wave_r;
        endcase
      end
    end else if (tick && act_r[1]) begin
      if (mode_r == M_FAST) begin
        if (cnt_r == CMAX)
          wave_nxt = ~act_r[0];
        else if (eq)
          wave_nxt = act_r[0];
      end else if (eq) begin
        wave_nxt = down ^ act_r[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r   <= '0;
      dn_r    <= 1'b0;
      wave_r  <= 1'b0;
      match_r <= 1'b0;
    end else begin
      match_r <= tick && eq;
      wave_r  <= wave_nxt;
      if (tick) begin
        cnt_r <= cnt_nxt;
        dn_r  <= dn_nxt;
      end else if (mode_r != M_PHASE) begin
        dn_r  <= 1'b0;
      end
    end
  end

  assign count   = cnt_r;
  assign match   = match_r;
  assign pin_out = (act_r != 2'd0) ? wave_r : port_r;
  assign pin_oe  = dir_r;

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_r == M_NORM && cnt_r == CMAX) |=> (cnt_r == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_r));
  a_r3_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_r == M_CTC && cnt_r == cmp_r) |=> (cnt_r == '0));
  a_r3_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !match);
  a_r6_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (force_act && !tick && !pwm && act_r == 2'd2) |=> !wave_r);
  a_r7_pwm_force: assert property (@(posedge clk) disable iff (!rst_n)
    (force_act && !tick && pwm) |=> $stable(wave_r));
  a_r9_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_r == M_PHASE && cnt_r == CMAX) |=> (cnt_r == CMAX - ONE));

endmodule

// File: tb/tb_cmp_wave_timer.sv
`timescale 1ns/1ps
module tb_cmp_wave_timer;
  localparam int W = 4;
  localparam int MX = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cfg_we = 1'b0, force_act = 1'b0;
  logic [W-1:0] cfg_cmp = '0;
  logic [1:0] cfg_act = 2'd0, cfg_mode = 2'd0;
  logic cfg_dir = 1'b0, cfg_port = 1'b0;
  logic [W-1:0] count;
  logic match, pin_out, pin_oe;
  int nchk = 0, nerr = 0;

  cmp_wave_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_cmp(cfg_cmp),
    .cfg_act(cfg_act), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .cfg_port(cfg_port),
    .force_act(force_act), .count(count), .match(match), .pin_out(pin_out), .pin_oe(pin_oe));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int cmp, input int act, input int mode, input bit dir, input bit port);
    @(negedge clk);
    tick = 1'b0;
    cfg_cmp = W'(cmp); cfg_act = 2'(act); cfg_mode = 2'(mode);
    cfg_dir = dir; cfg_port = port; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frc();
    @(negedge clk);
    tick = 1'b0; force_act = 1'b1;
    @(negedge clk);
    force_act = 1'b0;
  endtask

  task automatic run_ctc_action(input int cmp, input int init, input int act, input int n);
    int e = init;
    int prev = int'(count);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev == cmp) begin
        if (act == 1) e = 1 - e;
        else if (act == 2) e = 0;
        else if (act == 3) e = 1;
      end
      chk("R4 ctc action pin", int'(pin_out), e);
      prev = int'(count);
    end
    tick = 1'b0;
  endtask

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int prev, c0, pp, cur, e;
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 match", int'(match), 0);
    chk("R1 pin_out", int'(pin_out), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after release", int'(count), 0);

    cfg(0, 0, 0, 1, 1);
    chk("R10 port drives pin", int'(pin_out), 1);
    chk("R10 oe follows dir", int'(pin_oe), 1);
    cfg(0, 0, 0, 1, 0);
    chk("R10 port low", int'(pin_out), 0);
    cfg(0, 0, 0, 0, 1);
    chk("R10 oe off", int'(pin_oe), 0);
    chk("R10 pin data kept", int'(pin_out), 1);

    // R2 free-running count and wrap
    prev = int'(count);
    tick = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R2 increment/wrap", int'(count), (prev + 1) & MX);
      prev = int'(count);
    end
    tick = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 hold", int'(count), prev);
      chk("R3 no flag without tick", int'(match), 0);
    end

    // R11 same sequence with a nonzero action code
    cfg(3, 3, 0, 1, 0);
    prev = int'(count);
    tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R11 count unaffected by action", int'(count), (prev + 1) & MX);
      prev = int'(count);
    end
    tick = 1'b0;

    // R3 clear-on-compare sweep
    for (int k = 0; k <= MX; k++) begin
      cfg(k, 0, 2, 1, 0);
      prev = int'(count);
      tick = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        chk("R3 ctc next", int'(count), (prev == k) ? 0 : ((prev + 1) & MX));
        chk("R3 match flag", int'(match), (prev == k) ? 1 : 0);
        prev = int'(count);
      end
      tick = 1'b0;
    end

    // R6 force set, counter and flag untouched
    cfg(5, 3, 2, 1, 0);
    c0 = int'(count);
    frc();
    chk("R6 force set", int'(pin_out), 1);
    chk("R6 count unchanged", int'(count), c0);
    chk("R6 no flag", int'(match), 0);
    cfg(5, 1, 2, 1, 0);
    run_ctc_action(5, 1, 1, 50);
    cfg(5, 3, 2, 1, 0);
    frc();
    cfg(5, 2, 2, 1, 0);
    chk("R5 write does not clear", int'(pin_out), 1);
    run_ctc_action(5, 1, 2, 20);
    cfg(5, 2, 2, 1, 0);
    frc();
    chk("R6 force clear", int'(pin_out), 0);
    cfg(5, 3, 2, 1, 0);
    chk("R5 write does not set", int'(pin_out), 0);
    run_ctc_action(5, 0, 3, 20);
    cfg(5, 0, 2, 1, 0);
    tick = 1'b1;
    repeat (40) @(negedge clk);
    tick = 1'b0;
    cfg(5, 1, 2, 1, 0);
    chk("R4 action 0 left wave unchanged", int'(pin_out), 1);
    cfg(9, 2, 0, 1, 0);
    frc();
    chk("R6 force in free-running mode", int'(pin_out), 0);

    // R7 force ignored in PWM modes
    for (int m = 1; m <= 3; m += 2) begin
      cfg(7, 2, m, 1, 0);
      e = int'(pin_out);
      frc();
      chk("R7 force ignored (clear)", int'(pin_out), e);
      cfg(7, 3, m, 1, 0);
      e = int'(pin_out);
      frc();
      chk("R7 force ignored (set)", int'(pin_out), e);
    end

    // R8 single-slope PWM sweep
    for (int k = 0; k <= MX; k++) begin
      for (int a = 2; a <= 3; a++) begin
        cfg(k, a, 3, 1, 0);
        tick = 1'b1;
        repeat (2 * (MX + 1)) @(negedge clk);
        prev = int'(count);
        for (int i = 0; i <= MX; i++) begin
          @(negedge clk);
          cur = int'(count);
          chk("R8 fast count", cur, (prev + 1) & MX);
          e = (cur <= k) ? 1 : 0;
          if (a == 3) e = 1 - e;
          chk("R8 fast pin", int'(pin_out), e);
          prev = cur;
        end
        tick = 1'b0;
      end
    end

    // R9 dual-slope PWM sweep
    for (int k = 0; k <= MX; k++) begin
      for (int a = 2; a <= 3; a++) begin
        cfg(k, a, 1, 1, 0);
        tick = 1'b1;
        repeat (4 * (MX + 1)) @(negedge clk);
        pp = int'(count);
        @(negedge clk);
        prev = int'(count);
        for (int i = 0; i < 2 * MX + 2; i++) begin
          @(negedge clk);
          cur = int'(count);
          chk("R9 triangle count", cur,
              (prev == MX) ? MX - 1 : (prev == 0) ? 1 : (prev > pp) ? prev + 1 : prev - 1);
          if (k == 0) e = 0;
          else if (k == MX) e = 1;
          else e = ((cur < k) || (cur == k && cur > prev)) ? 1 : 0;
          if (a == 3) e = 1 - e;
          chk("R9 phase pin", int'(pin_out), e);
          pp = prev;
          prev = cur;
        end
        tick = 1'b0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule